// File: doc/BRIEF.md
# Serial Byte Receiver with Control/Status Register

This block turns an asynchronous serial line into bytes for a processor. The line passes through a two-stage synchronizer and is then watched with 8x oversampling. Each oversample is a cycle in which the `tick` clock-enable is high. A falling edge starts a frame. The edge only counts if the line is still low at the middle of the start bit. The data bits are then taken at their own mid-points, least-significant bit first. When configured, a parity bit follows the data bits and is checked. The stop bit is checked last. The finished byte moves into a data register and the buffer-full flag rises. That flag doubles as the interrupt request.

The processor reaches the block through one 8-bit control/status register and one read-only data register. Each register has its own read strobe, and the control/status register also has a write strobe. The control/status register holds three writable configuration bits and five read-only status flags:

| Bit | Meaning |
|-----|---------|
| 7 | parity error |
| 6 | overrun |
| 5 | framing error |
| 4 | receive busy |
| 3 | buffer full |
| 2 | odd parity select |
| 1 | parity on |
| 0 | receiver on |

A read strobe on the control/status register clears the three error flags. A read strobe on the data register clears buffer-full.

The frame engine is a five-state machine:

- **IDLE** waits for a low line sample on a tick while enabled (*start seen*).
- **START** counts to the start-bit mid-point. There it either falls back to IDLE on a high sample (*glitch reject*) or moves on to DATA (*start confirmed*).
- **DATA** takes eight mid-bit samples. After the last one it moves to PARITY if parity is on (*data to parity*), otherwise to STOP (*data to stop*).
- **PARITY** takes one sample and moves to STOP (*parity to stop*).
- **STOP** takes the stop sample, raises a one-cycle completion and returns to IDLE (*frame end*).

A low receiver-on bit forces any state back to IDLE (*abort*).

Top module: `uart_rx_csr`

## Requirements
- R1: After reset, `ctl_q`, `data_q` and `irq` are all zero.
- R2: A write strobe loads `wr_data[2:0]` into control bits 2..0 (bit 0 receiver on, bit 1 parity on, bit 2 odd parity), which read back on `ctl_q[2:0]`. Writes have no effect on bits 7..3.
- R3: With the receiver on, a frame of one low start bit, eight data bits sent LSB first and one stop bit, each lasting 8 ticks, places the byte on `data_q` and sets `ctl_q[3]`. With `tick` held high, this happens on clock edge 79 counted from the first edge that sees the line low; with parity on it happens on edge 87.
- R4: With parity on, one bit follows the data bits. For even parity (bit 2 = 0) the data and parity bits together hold an even count of ones; for odd parity they hold an odd count. A mismatch sets `ctl_q[7]` together with buffer-full, and a match leaves it 0.
- R5: A stop bit sampled low sets `ctl_q[5]` together with buffer-full; a high stop bit leaves it 0.
- R6: A frame that completes while buffer-full is already set, with no data-register read in that cycle, sets `ctl_q[6]`, and the new byte replaces the old one.
- R7: A read strobe on the control/status register clears bits 7..5 and leaves buffer-full unchanged.
- R8: A read strobe on the data register clears buffer-full. `irq` always equals buffer-full.
- R9: `ctl_q[4]` is 1 from the cycle after the start is detected until the frame completes, and 0 while idle.
- R10: A low pulse that is high again at the start-bit mid-point starts no reception: busy returns to 0 and buffer-full stays 0.
- R11: While the receiver-on bit is 0, the line is ignored and busy stays 0. Clearing the bit in the middle of a frame abandons that frame without setting buffer-full.
- R12: If a control/status read and a frame completion fall in the same cycle, the flags of the new frame are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversample enable, 8 per bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| wr_ctl | input | 1 | Write strobe for the control/status register |
| wr_data | input | 8 | Write data; bits 2..0 are used |
| rd_ctl | input | 1 | Read strobe of the control/status register (clears error flags) |
| rd_data | input | 1 | Read strobe of the data register (clears buffer-full) |
| ctl_q | output | 8 | Control/status register contents |
| data_q | output | 8 | Received byte |
| irq | output | 1 | Interrupt request, equal to buffer-full |

## Verification
With `tick` held high, a line change set up before clock edge k+1 reaches the state machine two edges later through the synchronizer. The completion of a frame without parity therefore lands on edge 79, and on edge 87 with parity. The bench drives the line at falling edges and samples `ctl_q` at the falling edge that follows edge 78 and edge 79 (or 86 and 87). It expects buffer-full exactly on the due edge. Effects of register strobes are due one edge after the strobe and are sampled at the next falling edge. The same-cycle priority test aims its read strobe at the computed completion edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    localparam int unsigned CTL_EN   = 0;
    localparam int unsigned CTL_PEN  = 1;
    localparam int unsigned CTL_PODD = 2;
    localparam int unsigned CTL_FULL = 3;
    localparam int unsigned CTL_BUSY = 4;
    localparam int unsigned CTL_FERR = 5;
    localparam int unsigned CTL_OVR  = 6;
    localparam int unsigned CTL_PERR = 7;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR   = 8,
    parameter int unsigned DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxs,
    input  logic             en,
    input  logic             par_en,
    input  logic             par_odd,
    output logic             busy,
    output logic             done,
    output logic [DBITS-1:0] byte_o,
    output logic             perr_o,
    output logic             ferr_o
);
    localparam int unsigned CW  = $clog2(OSR);
    localparam int unsigned BW  = $clog2(DBITS + 1);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] TOPB = BW'(DBITS - 1);

    rx_state_t        state, nxt;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bitn;
    logic [DBITS-1:0] shreg;
    logic             acc;
    logic             sample_pt;

    assign sample_pt = tick && (state == RX_START ? (cnt == MID) : (cnt == LAST));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick && !rxs) nxt = RX_START;
            RX_START:  if (sample_pt) nxt = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:   if (sample_pt && bitn == TOPB) nxt = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (sample_pt) nxt = RX_STOP;
            RX_STOP:   if (sample_pt) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
        if (!en) nxt = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        busy   = (state != RX_IDLE);
        done   = en && (state == RX_STOP) && sample_pt;
        byte_o = shreg;
        perr_o = par_en && (acc != par_odd);
        ferr_o = !rxs;
    end

    // bit timing and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            acc   <= 1'b0;
        end else if (tick) begin
            if (state == RX_IDLE || sample_pt) cnt <= '0;
            else                              cnt <= cnt + 1'b1;
            if (state == RX_START) begin
                bitn <= '0;
                acc  <= 1'b0;
            end
            if (sample_pt && state == RX_DATA) begin
                shreg <= {rxs, shreg[DBITS-1:1]};
                bitn  <= bitn + 1'b1;
                acc   <= acc ^ rxs;
            end
            if (sample_pt && state == RX_PARITY) acc <= acc ^ rxs;
        end
    end
endmodule

// File: rtl/uart_rx_csr.sv
module uart_rx_csr
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR   = 8,
    parameter int unsigned DBITS = 8,
    parameter int unsigned SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    input  logic             wr_ctl,
    input  logic [7:0]       wr_data,
    input  logic             rd_ctl,
    input  logic             rd_data,
    output logic [7:0]       ctl_q,
    output logic [DBITS-1:0] data_q,
    output logic             irq
);
    logic             rxs;
    logic [2:0]       cfg;
    logic             full, perr, ovr, ferr;
    logic [DBITS-1:0] rbuf;
    logic             frm_busy, frm_done, frm_perr, frm_ferr;
    logic [DBITS-1:0] frm_byte;

    uart_rx_sync #(.STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxs)
    );

    uart_rx_frame #(.OSR(OSR), .DBITS(DBITS)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rxs     (rxs),
        .en      (cfg[CTL_EN]),
        .par_en  (cfg[CTL_PEN]),
        .par_odd (cfg[CTL_PODD]),
        .busy    (frm_busy),
        .done    (frm_done),
        .byte_o  (frm_byte),
        .perr_o  (frm_perr),
        .ferr_o  (frm_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg <= '0;
        else if (wr_ctl) cfg <= wr_data[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            perr <= 1'b0;
            ovr  <= 1'b0;
            ferr <= 1'b0;
            rbuf <= '0;
        end else if (frm_done) begin
            rbuf <= frm_byte;
            full <= 1'b1;
            perr <= frm_perr;
            ferr <= frm_ferr;
            ovr  <= full && !rd_data;
        end else begin
            if (rd_data) full <= 1'b0;
            if (rd_ctl) begin
                perr <= 1'b0;
                ovr  <= 1'b0;
                ferr <= 1'b0;
            end
        end
    end

    assign ctl_q  = {perr, ovr, ferr, frm_busy, full, cfg};
    assign data_q = rbuf;
    assign irq    = full;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ctl,
    input logic [7:0] wr_data,
    input logic       rd_ctl,
    input logic       rd_data,
    input logic [7:0] ctl_q,
    input logic       irq,
    input logic       frame_done
);
    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> ctl_q[2:0] == $past(wr_data[2:0]));

    assert_done_sets_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> ctl_q[3]);

    assert_full_only_from_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[3]) |-> $past(frame_done));

    assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && ctl_q[3] && !rd_data) |=> ctl_q[6]);

    assert_read_clears_errors_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl && !frame_done) |=> ctl_q[7:5] == 3'b000);

    assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !frame_done) |=> !ctl_q[3]);

    assert_irq_is_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ctl_q[3]);

    assert_off_means_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctl_q[0]) |-> !ctl_q[4]);
endmodule

bind uart_rx_csr uart_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (wr_ctl),
    .wr_data    (wr_data),
    .rd_ctl     (rd_ctl),
    .rd_data    (rd_data),
    .ctl_q      (ctl_q),
    .irq        (irq),
    .frame_done (frm_done)
);

// File: tb/sim_uart_rx_csr.sv
`timescale 1ns/1ps
module sim_uart_rx_csr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rxd = 1'b1;
    logic       wr_ctl = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_ctl = 1'b0;
    logic       rd_data = 1'b0;
    logic [7:0] ctl_q;
    logic [7:0] data_q;
    logic       irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic full_pre, full_due, busy_mid;

    always #2.5 clk = ~clk;

    uart_rx_csr u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .wr_ctl(wr_ctl), .wr_data(wr_data), .rd_ctl(rd_ctl), .rd_data(rd_data),
        .ctl_q(ctl_q), .data_q(data_q), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            summary();
        end
    end

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); wr_ctl = 1'b1; wr_data = v;
        @(negedge clk); wr_ctl = 1'b0;
    endtask

    task automatic rd_ctl_pulse();
        @(negedge clk); rd_ctl = 1'b1;
        @(negedge clk); rd_ctl = 1'b0;
    endtask

    task automatic rd_data_pulse();
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drives one frame; k-th falling edge sets the level seen by edge k+1.
    task automatic drive(input logic [7:0] b, input logic pe, input logic po,
                         input logic flip_par, input logic stop_v,
                         input int rd_at, input int off_at);
        int nb;
        int due;
        logic pbit;
        logic v;
        nb   = pe ? 11 : 10;
        due  = pe ? 87 : 79;
        pbit = (^b) ^ po ^ flip_par;
        for (int k = 0; k < nb * 8; k++) begin
            @(negedge clk);
            if (k == due - 1) full_pre = ctl_q[3];
            if (k == due)     full_due = ctl_q[3];
            if (k == 40)      busy_mid = ctl_q[4];
            rd_ctl = (k == rd_at);
            wr_ctl = (k == off_at);
            wr_data = 8'h00;
            if (k / 8 == 0)              v = 1'b0;
            else if (k / 8 <= 8)         v = b[k/8 - 1];
            else if (pe && k / 8 == 9)   v = pbit;
            else                         v = stop_v;
            rxd = v;
        end
        @(negedge clk);
        rd_ctl = 1'b0; wr_ctl = 1'b0; rxd = 1'b1;
        idle(4);
    endtask

    initial begin
        idle(3);
        chk(ctl_q, 8'h00, "R1 ctl reset");
        chk(data_q, 8'h00, "R1 data reset");
        chk({7'd0, irq}, 8'h00, "R1 irq reset");
        rst_n = 1'b1;
        idle(2);
        chk(ctl_q, 8'h00, "R1 ctl after release");

        wr_cfg(8'hFF);
        chk(ctl_q, 8'h07, "R2 cfg write all ones");
        wr_cfg(8'hFA);
        chk(ctl_q, 8'h02, "R2 cfg write pattern");

        // Sweep: every byte in three configurations.
        for (int c = 0; c < 3; c++) begin
            logic [7:0] cf;
            cf = (c == 0) ? 8'h01 : (c == 1) ? 8'h03 : 8'h07;
            wr_cfg(cf);
            for (int b = 0; b < 256; b++) begin
                drive(8'(b), cf[1], cf[2], 1'b0, 1'b1, -1, -1);
                chk({7'd0, full_pre}, 8'h00, "R3 full early");
                chk({7'd0, full_due}, 8'h01, "R3 full on due edge");
                chk({7'd0, busy_mid}, 8'h01, "R9 busy mid-frame");
                chk(data_q, 8'(b), "R3 received byte");
                chk(ctl_q, {3'b000, 2'b01, cf[2:0]}, "R4 R5 R9 clean flags");
                rd_data_pulse();
                chk({7'd0, irq}, 8'h00, "R8 data read clears full");
            end
        end

        // Parity error, even and odd.
        for (int c = 0; c < 2; c++) begin
            logic [7:0] cf;
            cf = c ? 8'h07 : 8'h03;
            wr_cfg(cf);
            drive(8'h5C, 1'b1, cf[2], 1'b1, 1'b1, -1, -1);
            chk(ctl_q, {3'b100, 2'b01, cf[2:0]}, "R4 parity error flagged");
            rd_ctl_pulse();
            chk(ctl_q, {3'b000, 2'b01, cf[2:0]}, "R7 ctl read clears errors keeps full");
            rd_data_pulse();
        end

        // Framing error.
        wr_cfg(8'h01);
        drive(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, -1, -1);
        chk(ctl_q, 8'h29, "R5 framing error flagged");
        chk(data_q, 8'hA5, "R5 byte kept");
        rd_ctl_pulse();
        rd_data_pulse();
        chk(ctl_q, 8'h01, "R7 R8 all cleared");

        // Overrun.
        drive(8'h11, 1'b0, 1'b0, 1'b0, 1'b1, -1, -1);
        drive(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, -1, -1);
        chk(ctl_q, 8'h49, "R6 overrun flagged");
        chk(data_q, 8'h22, "R6 newer byte kept");
        rd_ctl_pulse();
        rd_data_pulse();

        // Same-cycle ctl read and completion.
        drive(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 78, -1);
        chk(ctl_q, 8'h29, "R12 new frame flag wins over read");
        rd_ctl_pulse();
        rd_data_pulse();

        // Glitch.
        @(negedge clk); rxd = 1'b0;
        @(negedge clk);
        @(negedge clk); rxd = 1'b1;
        @(negedge clk);
        chk({7'd0, ctl_q[4]}, 8'h01, "R9 busy after start seen");
        idle(30);
        chk(ctl_q, 8'h01, "R10 glitch rejected");

        // Receiver off.
        wr_cfg(8'h00);
        drive(8'h77, 1'b0, 1'b0, 1'b0, 1'b1, -1, -1);
        chk({7'd0, busy_mid}, 8'h00, "R11 off no busy");
        chk(ctl_q, 8'h00, "R11 off no reception");
        wr_cfg(8'h01);
        drive(8'h99, 1'b0, 1'b0, 1'b0, 1'b1, -1, 40);
        chk(ctl_q, 8'h00, "R11 mid-frame abort");

        summary();
    end
endmodule